// File: doc/BRIEF.md
# Reset-Time Program Loader

This block fills the 16-byte RAM of a small 8-bit bus-based CPU from a set of fixed programs held inside the block. On any clock edge with reset asserted, it samples a boot-enable input and a program selector. If boot is enabled, it owns the CPU's shared data bus once reset is released. It then drives the memory-address-register load and RAM write strobes in place of the CPU's control logic.

Each byte is copied in two cycles. In the first, the byte's address goes onto the bus and the address register is loaded. In the second, the byte itself goes onto the bus and the RAM is written. A whole program therefore takes exactly 32 cycles. The block then drops the bus, raises its done flag and stays quiet until the next reset. The bus value comes from a small priority multiplexer. The sequencer never requests two lanes at once.

Top module: `prog_loader`

## Requirements
- R1: When boot_en is high at the last clock edge with rst_n low, bus_own is high for exactly the 32 cycles that follow the release of rst_n, and for no other cycle.
- R2: In copy step 2k (k = 0..15, step 0 being the first cycle after release), bus_data equals k, mar_load is 1 and ram_write is 0.
- R3: In copy step 2k+1, bus_data equals byte k of the selected program p, ram_write is 1 and mar_load is 0. With the default 8-bit data width, byte k of program p is (53*p + 29*k + 7) mod 256.
- R4: prog_sel is sampled at the last clock edge with rst_n low. Changes to prog_sel after rst_n is released have no effect on the copied bytes.
- R5: A prog_sel value at or above the number of stored programs (default 5, so values 5 to 7) loads program 0.
- R6: When boot_en is low at the last reset edge, bus_own, mar_load and ram_write stay low, bus_data stays 0, and boot_done is high from the first cycle after release.
- R7: After step 31, bus_own, mar_load and ram_write are low, bus_data is 0, and boot_done stays high until the next reset, whatever boot_en and prog_sel do.
- R8: While rst_n is low, all outputs (bus_own, mar_load, ram_write, bus_data, boot_done) are 0.
- R9: mar_load and ram_write are never high together. Either strobe implies bus_own. bus_data is 0 whenever bus_own is low.
- R10: Asserting rst_n in the middle of a copy abandons it. The next release starts again at step 0 with the newly sampled prog_sel and boot_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its last edge arms or skips the copy |
| boot_en | input | 1 | Boot enable, sampled during reset |
| prog_sel | input | SEL_W (3) | Program selector, sampled during reset |
| bus_data | output | DATA_W (8) | Value this block drives onto the CPU bus |
| bus_own | output | 1 | High while this block owns the bus and strobes |
| mar_load | output | 1 | Address-register load strobe |
| ram_write | output | 1 | RAM write strobe |
| boot_done | output | 1 | High once the copy is over or was skipped |

## Verification
The bench goes after the out-of-range selector values. A design that indexed the program store with them would drive garbage bytes or wrap to another program. It also changes prog_sel and boot_en right after release and during the copy, which catches a design that keeps sampling them. A reset dropped into the middle of a copy shows whether the step counter restarts from zero. Checking every cycle after step 31 exposes an off-by-one in the length: a 31- or 33-cycle copy, or one that leaves a strobe or the bus owned after the final write.

// File: rtl/pl_pkg.sv
// Package pl_pkg
// Shared types and the computed program store contents for the
// reset-time program loader. Assumes data widths of at most 32 bits.
package pl_pkg;

    // Sequencer state: copying, or finished / skipped.
    typedef enum logic [0:0] {
        ST_COPY = 1'b0,
        ST_DONE = 1'b1
    } pl_state_e;

    // Byte stored at address a of program p, before truncation to the bus width.
    function automatic int unsigned prog_byte(input int unsigned p, input int unsigned a);
        return (p * 32'd53 + a * 32'd29 + 32'd7) % 32'd256;
    endfunction

endpackage

// File: rtl/pl_rom.sv
// Module pl_rom
// Fixed program store: NUM_PROGS programs of PROG_LEN words each,
// computed at elaboration from pl_pkg::prog_byte. Purely combinational
// read. Assumes prog_idx < NUM_PROGS (the sequencer clamps it).
module pl_rom #(
    parameter int NUM_PROGS = 5,
    parameter int PROG_LEN  = 16,
    parameter int DATA_W    = 8,
    localparam int PIDX_W   = (NUM_PROGS > 1) ? $clog2(NUM_PROGS) : 1,
    localparam int AIDX_W   = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1
) (
    input  logic [PIDX_W-1:0] prog_idx,
    input  logic [AIDX_W-1:0] word_idx,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] table_q [NUM_PROGS][PROG_LEN];

    // One constant word per program and address.
    for (genvar gp = 0; gp < NUM_PROGS; gp++) begin : g_prog
        for (genvar ga = 0; ga < PROG_LEN; ga++) begin : g_word
            localparam int unsigned VAL = pl_pkg::prog_byte(gp, ga);
            assign table_q[gp][ga] = DATA_W'(VAL);
        end
    end

    // Select the addressed word.
    always_comb begin
        word = table_q[int'(prog_idx)][int'(word_idx)];
    end

endmodule

// File: rtl/pl_seq.sv
// Module pl_seq
// Copy sequencer. On every reset edge it captures the boot decision and
// the clamped program selector. After release it runs 2*PROG_LEN steps:
// even steps request the address lane with an address-register load,
// odd steps request the data lane with a RAM write. It then parks in
// ST_DONE. Assumes the CPU is held off the bus while bus_own is high.
module pl_seq #(
    parameter int NUM_PROGS = 5,
    parameter int PROG_LEN  = 16,
    parameter int SEL_W     = 3,
    localparam int PIDX_W   = (NUM_PROGS > 1) ? $clog2(NUM_PROGS) : 1,
    localparam int AIDX_W   = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1,
    localparam int STEPS    = 2 * PROG_LEN,
    localparam int CNT_W    = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en,
    input  logic [SEL_W-1:0]  prog_sel,
    output logic [PIDX_W-1:0] prog_idx,
    output logic [AIDX_W-1:0] word_idx,
    output logic              addr_req,
    output logic              data_req,
    output logic              done
);
    import pl_pkg::*;

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

    pl_state_e         state_q;
    logic [CNT_W-1:0]  step_q;
    logic [PIDX_W-1:0] sel_q;
    logic              active;

    // Arm on reset edges, advance the step counter while copying.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= boot_en ? ST_COPY : ST_DONE;
            step_q  <= '0;
            sel_q   <= (int'(prog_sel) < NUM_PROGS) ? PIDX_W'(prog_sel) : '0;
        end else if (state_q == ST_COPY) begin
            step_q <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
                state_q <= ST_DONE;
            end
        end
    end

    // Lane requests and done flag, all silenced while reset is held.
    always_comb begin
        active   = rst_n && (state_q == ST_COPY);
        addr_req = active && !step_q[0];
        data_req = active &&  step_q[0];
        done     = rst_n && (state_q == ST_DONE);
        word_idx = step_q[CNT_W-1:1];
        prog_idx = sel_q;
    end

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COPY) |=> $stable(sel_q)); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R7

    AST_ADDR_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_req |=> data_req && $stable(word_idx)); // R2

endmodule

// File: rtl/pl_bus_mux.sv
// Module pl_bus_mux
// Priority multiplexer onto the shared bus: the highest-numbered lane
// with its request set wins, and no request yields zero. Assumes at most
// one request per cycle in normal use.
module pl_bus_mux #(
    parameter int LANES  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  req,
    input  logic [DATA_W-1:0] lane_data [LANES],
    output logic [DATA_W-1:0] bus_out
);

    // Walk lanes upward so the highest active lane overrides the rest.
    always_comb begin
        bus_out = '0;
        for (int i = 0; i < LANES; i++) begin
            if (req[i]) begin
                bus_out = lane_data[i];
            end
        end
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req)); // R9

endmodule

// File: rtl/prog_loader.sv
// Module prog_loader
// Reset-time program loader: copies one of several stored programs into
// the CPU RAM through the shared bus, an address load then a write per
// word, and signals completion. Assumes PROG_LEN <= 2**DATA_W so that
// addresses fit on the bus.
module prog_loader #(
    parameter int NUM_PROGS = 5,
    parameter int PROG_LEN  = 16,
    parameter int DATA_W    = 8,
    parameter int SEL_W     = 3,
    localparam int PIDX_W   = (NUM_PROGS > 1) ? $clog2(NUM_PROGS) : 1,
    localparam int AIDX_W   = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en,
    input  logic [SEL_W-1:0]  prog_sel,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_own,
    output logic              mar_load,
    output logic              ram_write,
    output logic              boot_done
);

    localparam int LANE_ADDR = 0;
    localparam int LANE_WORD = 1;

    logic [PIDX_W-1:0] prog_idx;
    logic [AIDX_W-1:0] word_idx;
    logic [DATA_W-1:0] rom_word;
    logic              addr_req;
    logic              data_req;
    logic [1:0]        req;
    logic [DATA_W-1:0] lanes [2];

    pl_seq #(
        .NUM_PROGS (NUM_PROGS),
        .PROG_LEN  (PROG_LEN),
        .SEL_W     (SEL_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_en  (boot_en),
        .prog_sel (prog_sel),
        .prog_idx (prog_idx),
        .word_idx (word_idx),
        .addr_req (addr_req),
        .data_req (data_req),
        .done     (boot_done)
    );

    pl_rom #(
        .NUM_PROGS (NUM_PROGS),
        .PROG_LEN  (PROG_LEN),
        .DATA_W    (DATA_W)
    ) u_rom (
        .prog_idx (prog_idx),
        .word_idx (word_idx),
        .word     (rom_word)
    );

    // Build the lane vectors for the bus multiplexer.
    always_comb begin
        req            = '0;
        req[LANE_ADDR] = addr_req;
        req[LANE_WORD] = data_req;
        lanes[LANE_ADDR] = DATA_W'(word_idx);
        lanes[LANE_WORD] = rom_word;
    end

    pl_bus_mux #(
        .LANES  (2),
        .DATA_W (DATA_W)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .lane_data (lanes),
        .bus_out   (bus_data)
    );

    // Strobes follow the lane that owns the bus this cycle.
    always_comb begin
        mar_load  = addr_req;
        ram_write = data_req;
        bus_own   = addr_req || data_req;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mar_load && ram_write)); // R9

    AST_STROBE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mar_load || ram_write) |-> bus_own); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (bus_data == '0)); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> !bus_own); // R7

endmodule

// File: tb/tb_prog_loader.sv
`timescale 1ns/1ps
module tb_prog_loader;

    localparam int NPROG = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_en = 1'b0;
    logic [2:0] prog_sel = '0;
    logic [7:0] bus_data;
    logic       bus_own, mar_load, ram_write, boot_done;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    prog_loader dut (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .prog_sel(prog_sel),
        .bus_data(bus_data), .bus_own(bus_own), .mar_load(mar_load),
        .ram_write(ram_write), .boot_done(boot_done)
    );

    always #5 clk = ~clk;

    // Expected program byte per the requirement formula.
    function automatic logic [7:0] want_byte(int p, int k);
        return 8'((53 * p + 29 * k + 7) % 256);
    endfunction

    // Expected {own, mar, wr, done, data} at copy step s (>=32 means after).
    function automatic logic [11:0] want(int s, bit en, int sel);
        int p;
        p = (sel < NPROG) ? sel : 0;
        if (!en || s >= 32) return {4'b0001, 8'h00};
        if (s % 2 == 0) return {4'b1100, 8'(s / 2)};
        return {4'b1010, want_byte(p, s / 2)};
    endfunction

    task automatic check(string tag, logic [11:0] exp);
        logic [11:0] got;
        got = {bus_own, mar_load, ram_write, boot_done, bus_data};
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s at %0t: got own/mar/wr/done=%b data=%h, expected %b data=%h",
                     tag, $time, got[11:8], got[7:0], exp[11:8], exp[7:0]);
        end
    endtask

    // One boot: reset with en/sel, then follow up to stop_at steps.
    task automatic boot(bit en, int sel, int stop_at, bit wiggle);
        @(negedge clk);
        rst_n = 1'b0; boot_en = en; prog_sel = 3'(sel);
        @(negedge clk); #2;
        check("R8 reset outputs", 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        if (wiggle) begin
            prog_sel = 3'($urandom_range(0, 7));   // R4: must be ignored
            boot_en = ~en;
        end
        for (int s = 0; s < stop_at; s++) begin
            #2;
            if (!en) check("R6 skipped boot", want(s, en, sel));
            else if (s >= 32) check("R7 after copy", want(s, en, sel));
            else if (s % 2 == 0) check("R2 R1 address step", want(s, en, sel));
            else check("R3 R4 R5 data step", want(s, en, sel));
            @(negedge clk);
            if (wiggle) begin
                prog_sel = 3'($urandom_range(0, 7));
                boot_en = 1'($urandom_range(0, 1));
            end
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // Directed cases.
        boot(1'b1, 0, 36, 1'b0);
        boot(1'b1, 4, 36, 1'b1);
        boot(1'b1, 5, 34, 1'b0);     // R5
        boot(1'b1, 7, 34, 1'b1);     // R5
        boot(1'b0, 2, 6, 1'b1);      // R6
        boot(1'b1, 3, 11, 1'b1);     // R10: aborted mid copy
        boot(1'b1, 1, 35, 1'b0);     // R10: restart from step 0
        boot(1'b1, 2, 7, 1'b0);      // R10
        boot(1'b0, 2, 4, 1'b0);      // R10 then skip
        // Random cases.
        for (int i = 0; i < 30; i++) begin
            boot(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
                 int'($urandom_range(20, 36)), 1'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule